// File: doc/BRIEF.md
# Shared-Pin Bus Cycle Owner Arbiter

This block sits between a host request port and two protocol engines that share one set of package pins: a PCI engine and a secondary ISA-style (Sub-ISA) engine. For each accepted host request it decides which engine owns the shared address, data and control pins, and it holds that choice until the owning engine reports the end of the cycle. The pins then rest for a fixed turnaround before the next owner may drive them. A cycle is routed to the Sub-ISA side in one of two ways. The first is an address decode: four programmable chip-select windows, or an I/O write to one of two debug-port addresses. The second is a subtractive claim: the cycle goes out on PCI first, and if no PCI target asserts DEVSEL# within a parameterised window, the Sub-ISA side takes it over.

The block also derives two helper strobes for external buffer transceivers. The first is a combined active-low read strobe from the I/O-read and memory-read strobes, which serves as the buffer direction. The second is an active-low buffer enable that is asserted while the Sub-ISA side owns the pins.

Top module: `pin_mux_arbiter`

## Requirements
- R1: A request goes to the Sub-ISA side when it hits an enabled chip-select window. Window i is hit when `((addr ^ base_i) & mask_i) == 0`. The base and mask of window i sit in bits [i*AW +: AW] of the flattened inputs, and its enable is bit i. Windows 0 and 1 match memory-space requests only, and windows 2 and 3 match I/O-space requests only (parameter `CS_IO_MAP` = 4'b1100).
- R2: An I/O write to address 80h or 84h goes to the Sub-ISA side. I/O reads of those addresses, memory accesses to them, and I/O writes to any other port outside the windows go to PCI.
- R3: A PCI-routed request raises `grant_pci` in the cycle after acceptance. When `devsel_n` is sampled low within the first `SUB_WAIT` PCI cycles, the grant holds until `pci_done` is sampled high, and no Sub-ISA cycle follows.
- R4: If `subtr_en` is high and `devsel_n` stays high for `SUB_WAIT` sampled PCI cycles, the PCI grant ends after exactly `SUB_WAIT` cycles. A turnaround follows, then a Sub-ISA cycle. With `subtr_en` low, the PCI grant lasts until `pci_done`.
- R5: A Sub-ISA cycle starts with `isa_start` high for exactly its first grant cycle. `grant_isa` stays high until `isa_done` is sampled high in a cycle after that start cycle.
- R6: `grant_pci` and `grant_isa` are never high together.
- R7: After every owned cycle, both grants stay low for exactly `TURN_CYC` cycles. No owner follows another without that gap.
- R8: `req_ready` is high only while no cycle or turnaround is in progress. A request is taken only while it is high, so requests made during a cycle stall.
- R9: `rd_n` is low whenever `ior_n` or `memr_n` is low, and high otherwise.
- R10: `trde_n` is low exactly while `grant_isa` is high.
- R11: After reset, both grants and `isa_start` are low, `trde_n` is high, and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_addr | input | AW | Request address |
| req_is_io | input | 1 | 1 = I/O space, 0 = memory space |
| req_is_wr | input | 1 | 1 = write, 0 = read |
| req_ready | output | 1 | Request accepted this cycle when high |
| cs_base | input | NCS*AW | Chip-select window bases, flattened |
| cs_mask | input | NCS*AW | Chip-select window compare masks, flattened |
| cs_en | input | NCS | Per-window enable |
| subtr_en | input | 1 | Sub-ISA side acts as subtractive agent |
| devsel_n | input | 1 | Sampled PCI DEVSEL#, active low |
| pci_done | input | 1 | PCI engine reports end of cycle |
| isa_done | input | 1 | Sub-ISA engine reports end of cycle |
| ior_n | input | 1 | Sub-ISA I/O read strobe, active low |
| memr_n | input | 1 | Sub-ISA memory read strobe, active low |
| grant_pci | output | 1 | PCI engine owns the shared pins |
| grant_isa | output | 1 | Sub-ISA engine owns the shared pins |
| isa_start | output | 1 | First cycle of a Sub-ISA transaction |
| rd_n | output | 1 | Combined read strobe for buffer direction |
| trde_n | output | 1 | Buffer transceiver enable, active low |

## Verification
The bench builds the block with `SUB_WAIT` = 3 and `TURN_CYC` = 2, so each subtractive timeout and each turnaround lasts only a few cycles. A DEVSEL# placed on either side of the window edge then lands within a short run. With a two-cycle turnaround, the bench can tell a one-cycle gap from a correct one. A subtractive transfer shows two separate turnaround gaps, so the bench measures the gap count as well as the gap length.

// File: rtl/pin_mux_pkg.sv
package pin_mux_pkg;

  typedef enum logic [2:0] {
    OWN_IDLE    = 3'd0,
    OWN_PCI     = 3'd1,
    OWN_TURN    = 3'd2,
    OWN_ISA_GO  = 3'd3,
    OWN_ISA_RUN = 3'd4
  } owner_state_e;

  function automatic logic window_hit(input logic [63:0] addr,
                                      input logic [63:0] base,
                                      input logic [63:0] mask);
    return (((addr ^ base) & mask) == 64'd0);
  endfunction

endpackage

// File: rtl/pin_mux_decode.sv
module pin_mux_decode #(
  parameter int          AW        = 32,
  parameter int          NCS       = 4,
  parameter logic [NCS-1:0] CS_IO_MAP = 4'b1100,
  parameter logic [AW-1:0] POST_A  = 'h80,
  parameter logic [AW-1:0] POST_B  = 'h84
) (
  input  logic [AW-1:0]     addr,
  input  logic              is_io,
  input  logic              is_wr,
  input  logic [NCS*AW-1:0] cs_base,
  input  logic [NCS*AW-1:0] cs_mask,
  input  logic [NCS-1:0]    cs_en,
  output logic              isa_hit
);
  import pin_mux_pkg::*;

  logic [NCS-1:0] win_match;
  logic           post_match;

  for (genvar gi = 0; gi < NCS; gi++) begin : g_win
    logic space_ok;
    logic [63:0] a_ext, b_ext, m_ext;
    assign space_ok = CS_IO_MAP[gi] ? is_io : ~is_io;
    assign a_ext = 64'(addr);
    assign b_ext = 64'(cs_base[gi*AW +: AW]);
    assign m_ext = 64'(cs_mask[gi*AW +: AW]);
    assign win_match[gi] = cs_en[gi] & space_ok & window_hit(a_ext, b_ext, m_ext);
  end

  always_comb begin
    post_match = is_io & is_wr & ((addr == POST_A) | (addr == POST_B));
    isa_hit    = (|win_match) | post_match;
  end

endmodule

// File: rtl/pin_mux_claim_timer.sv
module pin_mux_claim_timer #(
  parameter int SUB_WAIT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic devsel_n,
  output logic claimed,
  output logic expired
);
  localparam int CW = $clog2(SUB_WAIT + 1);
  localparam logic [CW-1:0] LAST = CW'(SUB_WAIT - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          claim_q, claim_d;
  logic          cnt_en;

  always_comb begin
    cnt_en  = run & devsel_n & ~claim_q & (cnt_q != LAST);
    cnt_d   = cnt_q;
    claim_d = claim_q;
    if (!run) begin
      cnt_d   = '0;
      claim_d = 1'b0;
    end else begin
      if (cnt_en)    cnt_d   = cnt_q + CW'(1);
      if (!devsel_n) claim_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      claim_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      claim_q <= claim_d;
    end
  end

  assign claimed = claim_q | (run & ~devsel_n);
  assign expired = run & devsel_n & ~claim_q & (cnt_q == LAST);

endmodule

// File: rtl/pin_mux_owner_fsm.sv
module pin_mux_owner_fsm #(
  parameter int TURN_CYC = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic isa_hit,
  input  logic subtr_en,
  input  logic expired,
  input  logic pci_done,
  input  logic isa_done,
  output logic req_ready,
  output logic pci_run,
  output logic grant_pci,
  output logic grant_isa,
  output logic isa_start,
  output logic trde_n
);
  import pin_mux_pkg::*;

  localparam int TW = (TURN_CYC > 1) ? $clog2(TURN_CYC) : 1;
  localparam logic [TW-1:0] TLAST = TW'(TURN_CYC - 1);

  owner_state_e st_q, st_d;
  logic [TW-1:0] turn_q, turn_d;
  logic          pend_q, pend_d;

  always_comb begin
    st_d   = st_q;
    turn_d = turn_q;
    pend_d = pend_q;
    unique case (st_q)
      OWN_IDLE: begin
        if (req_valid) st_d = isa_hit ? OWN_ISA_GO : OWN_PCI;
      end
      OWN_PCI: begin
        if (pci_done) begin
          st_d   = OWN_TURN;
          pend_d = 1'b0;
          turn_d = '0;
        end else if (expired && subtr_en) begin
          st_d   = OWN_TURN;
          pend_d = 1'b1;
          turn_d = '0;
        end
      end
      OWN_TURN: begin
        if (turn_q == TLAST) begin
          st_d   = pend_q ? OWN_ISA_GO : OWN_IDLE;
          pend_d = 1'b0;
        end else begin
          turn_d = turn_q + TW'(1);
        end
      end
      OWN_ISA_GO: st_d = OWN_ISA_RUN;
      OWN_ISA_RUN: begin
        if (isa_done) begin
          st_d   = OWN_TURN;
          pend_d = 1'b0;
          turn_d = '0;
        end
      end
      default: st_d = OWN_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= OWN_IDLE;
      turn_q <= '0;
      pend_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      turn_q <= turn_d;
      pend_q <= pend_d;
    end
  end

  always_comb begin
    req_ready = (st_q == OWN_IDLE);
    pci_run   = (st_q == OWN_PCI);
    grant_pci = (st_q == OWN_PCI);
    grant_isa = (st_q == OWN_ISA_GO) | (st_q == OWN_ISA_RUN);
    isa_start = (st_q == OWN_ISA_GO);
    trde_n    = ~grant_isa;
  end

endmodule

// File: rtl/pin_mux_arbiter.sv
module pin_mux_arbiter #(
  parameter int             AW        = 32,
  parameter int             NCS       = 4,
  parameter logic [NCS-1:0] CS_IO_MAP = 4'b1100,
  parameter int             SUB_WAIT  = 4,
  parameter int             TURN_CYC  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [AW-1:0]     req_addr,
  input  logic              req_is_io,
  input  logic              req_is_wr,
  output logic              req_ready,
  input  logic [NCS*AW-1:0] cs_base,
  input  logic [NCS*AW-1:0] cs_mask,
  input  logic [NCS-1:0]    cs_en,
  input  logic              subtr_en,
  input  logic              devsel_n,
  input  logic              pci_done,
  input  logic              isa_done,
  input  logic              ior_n,
  input  logic              memr_n,
  output logic              grant_pci,
  output logic              grant_isa,
  output logic              isa_start,
  output logic              rd_n,
  output logic              trde_n
);
  logic isa_hit, pci_run, claimed, expired;

  pin_mux_decode #(
    .AW(AW), .NCS(NCS), .CS_IO_MAP(CS_IO_MAP)
  ) u_decode (
    .addr(req_addr), .is_io(req_is_io), .is_wr(req_is_wr),
    .cs_base(cs_base), .cs_mask(cs_mask), .cs_en(cs_en),
    .isa_hit(isa_hit)
  );

  pin_mux_claim_timer #(.SUB_WAIT(SUB_WAIT)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(pci_run), .devsel_n(devsel_n),
    .claimed(claimed), .expired(expired)
  );

  pin_mux_owner_fsm #(.TURN_CYC(TURN_CYC)) u_fsm (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .isa_hit(isa_hit),
    .subtr_en(subtr_en), .expired(expired), .pci_done(pci_done),
    .isa_done(isa_done), .req_ready(req_ready), .pci_run(pci_run),
    .grant_pci(grant_pci), .grant_isa(grant_isa), .isa_start(isa_start),
    .trde_n(trde_n)
  );

  logic unused_claim;
  assign unused_claim = claimed;

  assign rd_n = ior_n & memr_n;

endmodule

// File: rtl/pin_mux_arbiter_chk.sv
module pin_mux_arbiter_chk (
  input logic clk,
  input logic rst_n,
  input logic req_ready,
  input logic grant_pci,
  input logic grant_isa,
  input logic isa_start,
  input logic isa_done,
  input logic trde_n,
  input logic rd_n,
  input logic ior_n,
  input logic memr_n
);
  AST_ONE_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
    !(grant_pci && grant_isa)); // R6
  AST_GAP_TO_ISA: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_isa && !$past(grant_isa)) |-> !$past(grant_pci)); // R7
  AST_GAP_TO_PCI: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_pci && !$past(grant_pci)) |-> !$past(grant_isa)); // R7
  AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!grant_pci && !grant_isa)); // R8
  AST_START_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    isa_start |-> (grant_isa && !$past(grant_isa))); // R5
  AST_START_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    isa_start |=> (grant_isa && !isa_start)); // R5
  AST_ISA_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_isa && !isa_start && !isa_done) |=> grant_isa); // R5
  AST_TRDE_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
    !trde_n |-> (grant_isa && !grant_pci)); // R10
  AST_RD_MERGE: assert property (@(posedge clk) disable iff (!rst_n)
    (!ior_n || !memr_n) |-> !rd_n); // R9
endmodule

bind pin_mux_arbiter pin_mux_arbiter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .grant_pci(grant_pci),
  .grant_isa(grant_isa), .isa_start(isa_start), .isa_done(isa_done),
  .trde_n(trde_n), .rd_n(rd_n), .ior_n(ior_n), .memr_n(memr_n)
);

// File: tb/pin_mux_arbiter_bench.sv
`timescale 1ns/1ps
module pin_mux_arbiter_bench;
  localparam int AW = 32;
  localparam int NCS = 4;
  localparam int SW = 3;
  localparam int TA = 2;

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid, req_is_io, req_is_wr, req_ready;
  logic [AW-1:0] req_addr;
  logic [NCS*AW-1:0] cs_base, cs_mask;
  logic [NCS-1:0] cs_en;
  logic subtr_en, devsel_n, pci_done, isa_done, ior_n, memr_n;
  logic grant_pci, grant_isa, isa_start, rd_n, trde_n;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  pin_mux_arbiter #(.AW(AW), .NCS(NCS), .CS_IO_MAP(4'b1100),
                    .SUB_WAIT(SW), .TURN_CYC(TA)) u_pin_mux_arbiter (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_is_io(req_is_io), .req_is_wr(req_is_wr), .req_ready(req_ready),
    .cs_base(cs_base), .cs_mask(cs_mask), .cs_en(cs_en), .subtr_en(subtr_en),
    .devsel_n(devsel_n), .pci_done(pci_done), .isa_done(isa_done),
    .ior_n(ior_n), .memr_n(memr_n), .grant_pci(grant_pci),
    .grant_isa(grant_isa), .isa_start(isa_start), .rd_n(rd_n), .trde_n(trde_n)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit model_isa(input logic [AW-1:0] a, input bit io, input bit wr);
    bit hit = 0;
    for (int i = 0; i < NCS; i++) begin
      bit io_win = (i >= 2);
      if (cs_en[i] && (io_win == io) &&
          (((a ^ cs_base[i*AW +: AW]) & cs_mask[i*AW +: AW]) == 0)) hit = 1;
    end
    if (io && wr && (a == 32'h80 || a == 32'h84)) hit = 1;
    return hit;
  endfunction

  int npci, nisa, nturn, nstart, nbad;

  task automatic run_txn(input logic [AW-1:0] a, input bit io, input bit wr,
                         input int dv, input int dn);
    int guard = 0;
    npci = 0; nisa = 0; nturn = 0; nstart = 0; nbad = 0;
    @(negedge clk);
    req_valid = 1; req_addr = a; req_is_io = io; req_is_wr = wr; devsel_n = 1;
    @(negedge clk);
    req_valid = 0; req_addr = $urandom;
    while (guard < 200) begin
      guard++;
      pci_done = 0; isa_done = 0;
      if (grant_pci) begin
        devsel_n = !(dv >= 0 && npci >= dv);
        if (dv >= 0 && npci == dv + dn) pci_done = 1;
        if (dv < 0 && npci == SW + 2) pci_done = 1;
        if (!trde_n || req_ready) nbad++;
        npci++;
      end else if (grant_isa) begin
        devsel_n = 1;
        if (isa_start) nstart++;
        if (isa_start != (nisa == 0)) nbad++;
        if (nisa == dn) isa_done = 1;
        if (trde_n || req_ready) nbad++;
        nisa++;
      end else if (!req_ready) begin
        devsel_n = 1;
        if (!trde_n || isa_start) nbad++;
        nturn++;
      end else begin
        break;
      end
      @(negedge clk);
    end
    pci_done = 0; isa_done = 0; devsel_n = 1;
  endtask

  task automatic txn_check(input logic [AW-1:0] a, input bit io, input bit wr,
                           input int dv, input int dn, input string tag);
    int e_pci, e_isa, e_turn, e_start;
    bit hit = model_isa(a, io, wr);
    run_txn(a, io, wr, dv, dn);
    if (hit) begin
      e_pci = 0; e_isa = dn + 1; e_turn = TA; e_start = 1;
    end else if (dv >= 0 && dv < SW) begin
      e_pci = dv + dn + 1; e_isa = 0; e_turn = TA; e_start = 0;
    end else if (subtr_en) begin
      e_pci = SW; e_isa = dn + 1; e_turn = 2 * TA; e_start = 1;
    end else begin
      e_pci = (dv >= 0) ? dv + dn + 1 : SW + 3; e_isa = 0; e_turn = TA; e_start = 0;
    end
    chk(npci == e_pci, {tag, " pci cycles"}, npci, e_pci);
    chk(nisa == e_isa, {tag, " isa cycles"}, nisa, e_isa);
    chk(nturn == e_turn, {tag, " R7 turnaround"}, nturn, e_turn);
    chk(nstart == e_start, {tag, " R5 start pulses"}, nstart, e_start);
    chk(nbad == 0, {tag, " R8/R10 per-cycle"}, nbad, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 0; req_valid = 0; req_addr = 0; req_is_io = 0; req_is_wr = 0;
    subtr_en = 0; devsel_n = 1; pci_done = 0; isa_done = 0; ior_n = 1; memr_n = 1;
    cs_base = {32'h0000_0370, 32'h0000_0300, 32'h000D_8000, 32'hFFFC_0000};
    cs_mask = {32'hFFFF_FFF8, 32'hFFFF_FFF0, 32'hFFFF_E000, 32'hFFFC_0000};
    cs_en = 4'b1111;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(!grant_pci && !grant_isa && !isa_start, "R11 grants", {grant_pci, grant_isa}, 0);
    chk(trde_n && req_ready, "R11 trde/ready", {trde_n, req_ready}, 3);
    rst_n = 1;
    @(negedge clk);

    // R9 combined read strobe
    for (int i = 0; i < 4; i++) begin
      ior_n = i[0]; memr_n = i[1];
      #1;
      chk(rd_n == (i == 3), "R9 rd_n", rd_n, i == 3);
    end
    ior_n = 1; memr_n = 1;

    // R1 windows
    txn_check(32'hFFFD_1234, 0, 0, -1, 2, "R1 rom mem read");
    txn_check(32'h000D_9FFE, 0, 1, -1, 1, "R1 doc mem write");
    txn_check(32'h0000_030C, 1, 0, -1, 3, "R1 io win2");
    txn_check(32'h0000_0377, 1, 1, -1, 1, "R1 io win3");
    txn_check(32'h0000_0304, 0, 0, 1, 1, "R1 io window ignores memory");
    cs_en = 4'b1110;
    txn_check(32'hFFFF_0000, 0, 0, 0, 2, "R1 disabled window");
    cs_en = 4'b1111;
    // R2 debug ports
    txn_check(32'h80, 1, 1, -1, 1, "R2 io write 80h");
    txn_check(32'h84, 1, 1, -1, 2, "R2 io write 84h");
    txn_check(32'h80, 1, 0, 0, 1, "R2 io read 80h");
    txn_check(32'h82, 1, 1, 2, 1, "R2 io write 82h");
    txn_check(32'h84, 0, 1, 1, 1, "R2 mem write 84h");
    // R3 claim edges and R4 subtractive
    subtr_en = 1;
    txn_check(32'h1000_0000, 0, 0, SW - 1, 2, "R3 late claim");
    txn_check(32'h1000_0000, 0, 0, SW, 1, "R4 subtractive edge");
    txn_check(32'h0000_0500, 1, 1, -1, 2, "R4 subtractive io");
    subtr_en = 0;
    txn_check(32'h1000_0000, 0, 0, -1, 1, "R4 no subtractive");
    txn_check(32'h1000_0000, 0, 0, 0, 4, "R3 immediate claim");

    // R8 stall: request during busy waits
    @(negedge clk);
    req_valid = 1; req_addr = 32'h80; req_is_io = 1; req_is_wr = 1;
    @(negedge clk);
    req_addr = 32'h2000_0000; req_is_io = 0;
    @(negedge clk);
    chk(grant_isa && !req_ready, "R8 busy no ready", req_ready, 0);
    req_valid = 0;
    isa_done = 1;
    @(negedge clk);
    isa_done = 0;
    chk(!grant_isa && !grant_pci, "R6 R7 gap after done", grant_isa, 0);
    repeat (TA) @(negedge clk);
    chk(req_ready && !grant_pci, "R8 stalled req not taken", grant_pci, 0);

    // random mix (R1 R2 R3 R4 R6)
    void'($urandom(32'h1234_5678));
    for (int n = 0; n < 80; n++) begin
      logic [AW-1:0] a;
      bit io, wr;
      int dv, dn;
      int sel = $urandom_range(0, 5);
      case (sel)
        0: a = 32'hFFFC_0000 | ($urandom & 32'h3FFFF);
        1: a = 32'h000D_8000 | ($urandom & 32'h3FFF);
        2: a = 32'h0000_0300 | ($urandom & 32'h7F);
        3: a = ($urandom & 1) ? 32'h80 : 32'h84;
        4: a = $urandom & 32'hFF;
        default: a = $urandom;
      endcase
      io = $urandom & 1; wr = $urandom & 1;
      dv = $urandom_range(0, SW + 1) - 1;
      dn = $urandom_range(1, 3);
      subtr_en = $urandom & 1;
      txn_check(a, io, wr, dv, dn, "R3 R4 random");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule